// File: doc/BRIEF.md
# SPI Control and Diagnostic Shift Interface

This block is the serial front end of an eight-channel output controller. A host talks to it over a four-wire SPI link with clock polarity 0 and clock phase 1. The host pulls chip select low, clocks in a control byte and, over the same clocks, receives a diagnostic byte. When chip select falls, the eight channel diagnostic inputs are copied into the shift register. When chip select rises, the received byte moves into an eight-bit output latch that switches the channels on or off. The move happens only when the frame carried a whole number of bytes.

The block runs on a fast system clock. It passes SCK, chip select and MOSI through synchronizers and acts on their edges. On the wire, the byte is not in channel order: bit positions are interleaved by channel. MISO comes out with a separate drive-enable, so a pad tri-state buffer can be placed outside the block. An active-low reset and a low-supply flag each clear the output latch at once, without waiting for a clock.

Top module: `spi_octal_ctrl`

## Requirements
- R1: Either `rst_n` low or `supply_low` high clears `chan_on` to all zeros at once, without waiting for a clock edge, and `chan_on` stays zero while that condition holds.
- R2: `miso_oe` is 0 while `cs_n` is high and 1 while a frame is open (`cs_n` low).
- R3: On the falling edge of `cs_n`, the current `diag_i` values are captured. The first bit presented on MISO is the wire MSB of the diagnostic byte, which carries channel 1.
- R4: MISO changes only after a rising SCK edge and MOSI is sampled on falling SCK edges, MSB first. After the eight diagnostic bits, MISO repeats the MOSI bits received earlier in the frame, delayed by eight clocks.
- R5: Wire bits 7 down to 0 of the control byte and of the diagnostic byte belong to channels 1, 3, 5, 7, 0, 2, 4, 6 in that order. `chan_on[k]` and `diag_i[k]` refer to channel k.
- R6: A frame with exactly eight SCK cycles loads the received byte into `chan_on` when `cs_n` rises, and `chan_on` does not change while `cs_n` is low.
- R7: A frame with 16 or any other nonzero multiple of eight SCK cycles loads the last eight bits received.
- R8: A frame whose SCK count is not a multiple of eight (for example 5 or 12) leaves `chan_on` unchanged.
- R9: A frame with no SCK cycles leaves `chan_on` unchanged.
- R10: SCK and MOSI activity while `cs_n` is high has no effect. `chan_on` keeps its value and the SCK count of the next frame starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_low | input | 1 | Low-supply flag, acts like reset when high |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial control data from the host |
| diag_i | input | 8 | Diagnostic level per channel, index = channel |
| miso | output | 1 | Serial diagnostic data to the host |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| chan_on | output | 8 | Latched on/off control per channel, index = channel |

## Verification
The assertions rely on three properties of the inputs:
- Each SCK level lasts several system clocks.
- MOSI is steady across the synchronizer delay around each falling SCK edge.
- No SCK edge reaches the synchronizers in the same cycle as a chip-select edge.

The stimulus keeps within these limits. It holds each SCK half period for eight system clocks. It changes MOSI only together with a rising SCK edge. It leaves eight clocks of lead time after chip select falls and six clocks of lag before chip select rises. Idle-time SCK pulses are sent only while chip select is high, well away from any chip-select edge.

// File: rtl/octl_pkg.sv
package octl_pkg;

    localparam int NCH   = 8;
    localparam int CNT_W = $clog2(NCH);

    typedef logic [NCH-1:0] byte_t;

    // end-of-frame information handed from the shifter to the latch
    typedef struct packed {
        logic             close;   // chip select just went high
        logic             clocked; // at least one SCK fall in the frame
        logic [CNT_W-1:0] phase;   // SCK falls modulo eight
    } frame_t;

    // wire bit position of a channel: odd channels fill the upper half
    function automatic int wire_pos(input int ch);
        if (ch % 2 == 1) return (NCH - 1) - (ch - 1) / 2;
        else             return (NCH / 2 - 1) - ch / 2;
    endfunction

    function automatic byte_t chan_to_wire(input byte_t c);
        byte_t w;
        w = '0;
        for (int ch = 0; ch < NCH; ch++) w[wire_pos(ch)] = c[ch];
        return w;
    endfunction

    function automatic byte_t wire_to_chan(input byte_t w);
        byte_t c;
        c = '0;
        for (int ch = 0; ch < NCH; ch++) c[ch] = w[wire_pos(ch)];
        return c;
    endfunction

endpackage

// File: rtl/octl_sync.sv
module octl_sync #(
    parameter int               WIDTH  = 1,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/octl_shifter.sv
module octl_shifter
    import octl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sck_s,
    input  logic   cs_s,
    input  logic   mosi_s,
    input  byte_t  diag_wire,
    output logic   miso_q,
    output byte_t  shreg,
    output frame_t frm
);

    logic             sck_d, cs_d;
    logic             cs_fall, sck_rise, sck_fall;
    logic [CNT_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign cs_fall  = cs_d & ~cs_s;
    assign sck_rise = ~cs_s & sck_s & ~sck_d;
    assign sck_fall = ~cs_s & ~sck_s & sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            seen   <= 1'b0;
            miso_q <= 1'b0;
        end else if (cs_fall) begin
            shreg  <= diag_wire;
            cnt    <= '0;
            seen   <= 1'b0;
            miso_q <= diag_wire[NCH-1];
        end else begin
            if (sck_rise) miso_q <= shreg[NCH-1];
            if (sck_fall) begin
                shreg <= {shreg[NCH-2:0], mosi_s};
                cnt   <= cnt + 1'b1;
                seen  <= 1'b1;
            end
        end
    end

    assign frm.close   = cs_s & ~cs_d;
    assign frm.clocked = seen;
    assign frm.phase   = cnt;

    AST_IDLE_IGNORES_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> ($stable(shreg) && $stable(cnt))); // R10

    AST_MISO_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !cs_fall) |=> $stable(miso_q)); // R4

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && !cs_fall) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R7

endmodule

// File: rtl/spi_octal_ctrl.sv
module spi_octal_ctrl
    import octl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           supply_low,
    input  logic           sck,
    input  logic           cs_n,
    input  logic           mosi,
    input  logic [NCH-1:0] diag_i,
    output logic           miso,
    output logic           miso_oe,
    output logic [NCH-1:0] chan_on
);

    logic   rst_all_n;
    logic   cs_s, sck_s, mosi_s;
    logic   miso_q;
    byte_t  shreg;
    byte_t  latch_q;
    frame_t frm;
    logic   frame_ok;

    assign rst_all_n = rst_n & ~supply_low;

    octl_sync #(.WIDTH(3), .STAGES(2), .INIT(3'b100)) sync_i (
        .clk   (clk),
        .rst_n (rst_all_n),
        .d     ({cs_n, sck, mosi}),
        .q     ({cs_s, sck_s, mosi_s})
    );

    octl_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_all_n),
        .sck_s     (sck_s),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .diag_wire (chan_to_wire(diag_i)),
        .miso_q    (miso_q),
        .shreg     (shreg),
        .frm       (frm)
    );

    assign frame_ok = frm.close & frm.clocked & (frm.phase == '0);

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n)    latch_q <= '0;
        else if (frame_ok) latch_q <= wire_to_chan(shreg);
    end

    assign chan_on = latch_q;
    assign miso    = miso_q;
    assign miso_oe = ~cs_s;

    AST_LATCH_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_all_n)
        !cs_s |=> $stable(latch_q)); // R6

    AST_PARTIAL_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_all_n)
        (frm.close && (frm.phase != '0)) |=> $stable(latch_q)); // R8

    AST_EMPTY_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_all_n)
        (frm.close && !frm.clocked) |=> $stable(latch_q)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_all_n |-> (chan_on == '0)); // R1

endmodule

// File: tb/spi_octal_ctrl_tb_top.sv
module spi_octal_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;

    logic       clk = 1'b0;
    logic       rst_n, supply_low, sck, cs_n, mosi;
    logic [7:0] diag;
    logic       miso, miso_oe;
    logic [7:0] chan_on;

    int   n_checks = 0;
    int   n_err    = 0;
    bit   done     = 0;
    logic exp_q[$];
    logic [7:0] exp_latch;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_octal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .diag_i(diag), .miso(miso),
        .miso_oe(miso_oe), .chan_on(chan_on)
    );

    // R5: wire bits 7..0 carry channels 1,3,5,7,0,2,4,6
    function automatic logic [7:0] tb_chan_of(input logic [7:0] w);
        int ord[8] = '{1, 3, 5, 7, 0, 2, 4, 6};
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[ord[i]] = w[7-i];
        return c;
    endfunction

    function automatic logic [7:0] tb_wire_of(input logic [7:0] c);
        int ord[8] = '{1, 3, 5, 7, 0, 2, 4, 6};
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[7-i] = c[ord[i]];
        return w;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: the host samples MISO on each falling SCK edge
    always @(negedge sck) begin
        if (!cs_n && exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            check(miso === e, "R3/R4 miso bit", {7'b0, miso}, {7'b0, e});
        end
    end

    // driver: one frame of n SCK cycles, bits sent MSB first from bits[n-1]
    task automatic xfer(input logic [31:0] bits, input int n, input string req);
        logic [7:0] dw;
        dw = tb_wire_of(diag);
        exp_q.delete();
        for (int i = 0; i < n; i++)
            exp_q.push_back(i < 8 ? dw[7-i] : bits[n-1-(i-8)]);
        cs_n = 1'b0;
        wclk(8);
        check(miso_oe === 1'b1, "R2 oe in frame", {7'b0, miso_oe}, 8'h01);
        for (int i = 0; i < n; i++) begin
            sck  = 1'b1;
            mosi = bits[n-1-i];
            wclk(HALF_SCK);
            sck = 1'b0;
            wclk(HALF_SCK);
        end
        wclk(6);
        cs_n = 1'b1;
        wclk(10);
        if (n > 0 && n % 8 == 0) exp_latch = tb_chan_of(bits[7:0]);
        check(chan_on === exp_latch, req, chan_on, exp_latch);
        check(miso_oe === 1'b0, "R2 oe idle", {7'b0, miso_oe}, 8'h00);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; supply_low = 1'b0; sck = 1'b0; cs_n = 1'b1;
        mosi = 1'b0; diag = 8'hA5; exp_latch = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        check(chan_on === 8'h00, "R1 reset state", chan_on, 8'h00);
        check(miso_oe === 1'b0, "R2 idle after reset", {7'b0, miso_oe}, 8'h00);

        xfer(32'h80, 8, "R5 wire msb to ch1");
        xfer(32'h01, 8, "R5 wire lsb to ch6");
        diag = 8'h3C;
        xfer(32'hC6, 8, "R6 eight clocks");
        xfer(32'hF00F, 16, "R7 sixteen clocks");
        xfer(32'h1B, 5, "R8 five clocks");
        xfer(32'hABC, 12, "R8 twelve clocks");
        xfer(32'h0, 0, "R9 no clocks");

        // R10: SCK pulses while deselected
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; mosi = 1'b1; wclk(HALF_SCK);
            sck = 1'b0; wclk(HALF_SCK);
        end
        wclk(10);
        check(chan_on === exp_latch, "R10 idle sck no effect", chan_on, exp_latch);
        check(miso_oe === 1'b0, "R10 idle oe", {7'b0, miso_oe}, 8'h00);
        xfer(32'h55, 8, "R10 count restarts");

        // R1: asynchronous reset
        rst_n = 1'b0;
        #1;
        check(chan_on === 8'h00, "R1 async reset", chan_on, 8'h00);
        wclk(3);
        rst_n = 1'b1;
        exp_latch = 8'h00;
        wclk(5);

        diag = 8'h81;
        xfer(32'hFF, 8, "R3 fresh diag after reset");

        // R1: low-supply flag
        supply_low = 1'b1;
        #1;
        check(chan_on === 8'h00, "R1 low supply clears", chan_on, 8'h00);
        wclk(3);
        supply_low = 1'b0;
        exp_latch = 8'h00;
        wclk(5);
        diag = 8'h5A;
        xfer(32'h3C, 8, "R6 after low supply");

        done = 1;
        summary();
        $finish;
    end

endmodule